// File: doc/BRIEF.md
# Overvoltage Fault Response Controller

This block decides how a power stage reacts when an input overvoltage comparator fires. An 8-bit configuration byte selects one of three reactions: keep running, shut down after a programmed number of switching cycles if the fault is still there, or shut down at once. After any shutdown the block can wait out a hiccup interval and try to start again. It makes a limited or unlimited number of such attempts and latches off once the allowance is used up.

The configuration byte is written over a single-cycle write strobe and can be read back at all times. A write that carries the unsupported reaction code is discarded. The block then sets a sticky invalid-data flag and raises a host alert. One shared three-bit code sets both the shutdown delay and the hiccup length. The two use different, non-linear mappings of that code. Switching-cycle and soft-start rise-time ticks come from outside as one-cycle pulses.

Top module: `ovp_resp_ctrl`

## Requirements
- R1: After reset the configuration reads 8'h8A. Bits [7:6] hold the reaction, bits [5:3] hold the retry allowance and bits [2:0] hold the timing code. run_out, latched_off, inv_data_flag and host_alert are all 0.
- R2: A write with bits [7:6] = 2'b11 is discarded, and the stored byte is unchanged. inv_data_flag is 1 from the next cycle on and stays 1 until a valid write clears it. host_alert is 1 for exactly the one cycle after the rejected write.
- R3: A valid write is visible on cfg_rd_data in the next cycle. The state machine acts on the new value from that cycle on, even while the stage is running.
- R4: While fault_in is 1, start-up is held off in every reaction mode. With enable_in at 1, run_out rises in the cycle after fault_in is first seen at 0.
- R5: Reaction 2'b00: a fault while running never lowers run_out.
- R6: Reaction 2'b10: a fault seen while run_out is 1 makes run_out 0 in the next cycle.
- R7: Reaction 2'b01: the fault is first seen at a clock edge. From the cycle after that edge, run_out falls on the D-th sw_tick, where D is 1 for codes 0–1, 3 for codes 2–4 and 7 for codes 5–7.
- R8: Reaction 2'b01: if the fault clears before the delay expires, no shutdown occurs, and a later fault starts a fresh count of D ticks.
- R9: After a shutdown that is not a latch-off, the block waits H rise_ticks and then attempts a restart. H is 1 for codes 0–1 and equals the code for codes 2–7.
- R10: Retry allowance 0 latches off at the first shutdown. An allowance N of 1–6 latches off when the N-th attempt fails. An attempt made while fault_in is 1 is counted as a failure, and run_out stays 0 during it.
- R11: Retry allowance 7 never latches off, however many attempts fail.
- R12: A start-up succeeds when a rise_tick arrives in the start-up phase without a shutdown. Success moves the block to steady running and clears the attempt count.
- R13: Lowering enable_in returns the block to idle in the next cycle, with run_out 0 and latched_off 0. It also clears the attempt count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 8 | Configuration byte to write |
| cfg_rd_data | output | 8 | Stored configuration byte |
| enable_in | input | 1 | On command |
| fault_in | input | 1 | Overvoltage comparator output |
| sw_tick | input | 1 | One pulse per switching cycle |
| rise_tick | input | 1 | One pulse per soft-start rise time |
| run_out | output | 1 | 1 = power stage may switch |
| latched_off | output | 1 | 1 = retries exhausted, held off |
| inv_data_flag | output | 1 | Sticky rejected-write status |
| host_alert | output | 1 | Host notification pulse on rejected write |

## Verification
The bench sweeps all eight timing codes twice: once for the shutdown delay and once for the hiccup length. Each sweep samples one tick before and exactly at the expected edge. This catches an off-by-one counter or a linear, unmapped code, both of which would move the edge. Every retry allowance from 1 to 6 is exercised with the fault held high. A design that did not count the invisible attempts would never latch off, and one that latched a step early would do so before the N-th tick. Separate cases cover a fault that clears mid-delay, which a counter that is not reset would shut down too early. They also cover a successful start-up between failures: a count that was never cleared would latch at the first later shutdown. Finally, a rejected write must leave the stored byte intact while still pulsing the alert.

// File: rtl/ovp_resp_pkg.sv
package ovp_resp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_START  = 3'd1,
      ST_RUN    = 3'd2,
      ST_DELAY  = 3'd3,
      ST_HICCUP = 3'd4,
      ST_LATCH  = 3'd5
   } ovp_state_e;

   localparam logic [1:0] RESP_IGNORE  = 2'b00;
   localparam logic [1:0] RESP_DELAYED = 2'b01;
   localparam logic [1:0] RESP_IMMED   = 2'b10;
   localparam logic [1:0] RESP_BAD     = 2'b11;

endpackage

// File: rtl/ovp_tick_counter.sv
module ovp_tick_counter #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [CNT_W-1:0] target,
   output logic             hit
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   cnt_plus;

   assign cnt_plus = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
   assign hit      = tick && (cnt_plus >= {1'b0, target});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (tick && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_plus[CNT_W-1:0];
      end
   end

endmodule

// File: rtl/ovp_code_map.sv
module ovp_code_map #(
   parameter int CODE_W = 3,
   parameter int CNT_W  = 4
) (
   input  logic [CODE_W-1:0] code,
   output logic [CNT_W-1:0]  dly_cycles,
   output logic [CNT_W-1:0]  hic_mult
);

   if (CODE_W != 3) begin : g_code_w_chk
      $error("ovp_code_map: CODE_W must be 3");
   end
   if (CNT_W < CODE_W) begin : g_cnt_w_chk
      $error("ovp_code_map: CNT_W must hold the largest code");
   end

   localparam logic [CODE_W-1:0] LOW_TOP = CODE_W'(1);
   localparam logic [CODE_W-1:0] MID_TOP = CODE_W'(4);

   always_comb begin
      if (code <= LOW_TOP) begin
         dly_cycles = CNT_W'(1);
      end else if (code <= MID_TOP) begin
         dly_cycles = CNT_W'(3);
      end else begin
         dly_cycles = CNT_W'(7);
      end
   end

   always_comb begin
      if (code <= LOW_TOP) begin
         hic_mult = CNT_W'(1);
      end else begin
         hic_mult = CNT_W'(code);
      end
   end

endmodule

// File: rtl/ovp_cfg_reg.sv
module ovp_cfg_reg #(
   parameter int               CFG_W       = 8,
   parameter int               MODE_W      = 2,
   parameter logic [CFG_W-1:0] RESET_CFG   = 8'h8A,
   parameter bit               ALERT_PULSE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   output logic [CFG_W-1:0] cfg_q,
   output logic             inv_flag,
   output logic             alert
);

   localparam logic [MODE_W-1:0] MODE_ALL_ONES = {MODE_W{1'b1}};

   logic bad_wr;

   assign bad_wr = wr_en && (wr_data[CFG_W-1 -: MODE_W] == MODE_ALL_ONES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= RESET_CFG;
         inv_flag <= 1'b0;
      end else if (wr_en) begin
         if (bad_wr) begin
            inv_flag <= 1'b1;
         end else begin
            cfg_q    <= wr_data;
            inv_flag <= 1'b0;
         end
      end
   end

   if (ALERT_PULSE) begin : g_alert_pulse
      logic alert_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) alert_q <= 1'b0;
         else        alert_q <= bad_wr;
      end
      assign alert = alert_q;
   end else begin : g_alert_level
      assign alert = inv_flag;
   end

endmodule

// File: rtl/ovp_resp_ctrl.sv
module ovp_resp_ctrl
   import ovp_resp_pkg::*;
#(
   parameter int                 MODE_W      = 2,
   parameter int                 RETRY_W     = 3,
   parameter int                 CODE_W      = 3,
   parameter int                 CFG_W       = MODE_W + RETRY_W + CODE_W,
   parameter int                 CNT_W       = 4,
   parameter logic [CFG_W-1:0]   RESET_CFG   = 8'h8A,
   parameter bit                 ALERT_PULSE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr_en,
   input  logic [CFG_W-1:0] cfg_wr_data,
   output logic [CFG_W-1:0] cfg_rd_data,
   input  logic             enable_in,
   input  logic             fault_in,
   input  logic             sw_tick,
   input  logic             rise_tick,
   output logic             run_out,
   output logic             latched_off,
   output logic             inv_data_flag,
   output logic             host_alert
);

   if (MODE_W != 2) begin : g_mode_w_chk
      $error("ovp_resp_ctrl: MODE_W must be 2");
   end
   if (CFG_W != MODE_W + RETRY_W + CODE_W) begin : g_cfg_w_chk
      $error("ovp_resp_ctrl: CFG_W must equal the sum of field widths");
   end

   localparam int                 MODE_LSB      = RETRY_W + CODE_W;
   localparam int                 RETRY_LSB     = CODE_W;
   localparam logic [RETRY_W-1:0] RETRY_FOREVER = {RETRY_W{1'b1}};
   localparam logic [RETRY_W-1:0] RETRY_NONE    = '0;

   logic [CFG_W-1:0]   cfg_q;
   logic [MODE_W-1:0]  resp_mode;
   logic [RETRY_W-1:0] retry_set;
   logic [CODE_W-1:0]  tcode;
   logic [CNT_W-1:0]   dly_cycles;
   logic [CNT_W-1:0]   hic_mult;

   ovp_cfg_reg #(
      .CFG_W      (CFG_W),
      .MODE_W     (MODE_W),
      .RESET_CFG  (RESET_CFG),
      .ALERT_PULSE(ALERT_PULSE)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_data (cfg_wr_data),
      .cfg_q   (cfg_q),
      .inv_flag(inv_data_flag),
      .alert   (host_alert)
   );

   assign resp_mode   = cfg_q[MODE_LSB +: MODE_W];
   assign retry_set   = cfg_q[RETRY_LSB +: RETRY_W];
   assign tcode       = cfg_q[0 +: CODE_W];
   assign cfg_rd_data = cfg_q;

   ovp_code_map #(
      .CODE_W(CODE_W),
      .CNT_W (CNT_W)
   ) u_map (
      .code      (tcode),
      .dly_cycles(dly_cycles),
      .hic_mult  (hic_mult)
   );

   ovp_state_e         st_q, st_nx;
   logic [RETRY_W-1:0] att_q, att_nx, att_inc;
   logic               cnt_clr, cnt_tick, cnt_hit;
   logic [CNT_W-1:0]   cnt_target;

   always_comb begin
      cnt_tick = (st_q == ST_DELAY) ? sw_tick : rise_tick;
      case (st_q)
         ST_DELAY:  cnt_target = dly_cycles;
         ST_HICCUP: cnt_target = hic_mult;
         default:   cnt_target = CNT_W'(1);
      endcase
   end

   ovp_tick_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .tick  (cnt_tick),
      .target(cnt_target),
      .hit   (cnt_hit)
   );

   assign att_inc = (att_q == RETRY_FOREVER) ? att_q : att_q + 1'b1;

   function automatic ovp_state_e shut_to(input logic [RETRY_W-1:0] setting,
                                          input logic [RETRY_W-1:0] used);
      if (setting == RETRY_NONE)         return ST_LATCH;
      else if (setting == RETRY_FOREVER) return ST_HICCUP;
      else if (used >= setting)          return ST_LATCH;
      else                               return ST_HICCUP;
   endfunction

   always_comb begin
      st_nx  = st_q;
      att_nx = att_q;
      if (!enable_in) begin
         st_nx  = ST_IDLE;
         att_nx = '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (!fault_in) st_nx = ST_START;
            end
            ST_START, ST_RUN: begin
               if (fault_in && (resp_mode == RESP_IMMED)) begin
                  st_nx = shut_to(retry_set, att_q);
               end else if (fault_in && (resp_mode == RESP_DELAYED)) begin
                  st_nx = ST_DELAY;
               end else if ((st_q == ST_START) && cnt_hit) begin
                  st_nx  = ST_RUN;
                  att_nx = '0;
               end
            end
            ST_DELAY: begin
               if (!fault_in || (resp_mode == RESP_IGNORE)) begin
                  st_nx = ST_RUN;
               end else if ((resp_mode == RESP_IMMED) || cnt_hit) begin
                  st_nx = shut_to(retry_set, att_q);
               end
            end
            ST_HICCUP: begin
               if (cnt_hit) begin
                  att_nx = att_inc;
                  if (fault_in) st_nx = shut_to(retry_set, att_inc);
                  else          st_nx = ST_START;
               end
            end
            ST_LATCH: begin
               st_nx = ST_LATCH;
            end
            default: begin
               st_nx = ST_IDLE;
            end
         endcase
      end
   end

   assign cnt_clr = (st_nx != st_q) || cnt_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         att_q <= '0;
      end else begin
         st_q  <= st_nx;
         att_q <= att_nx;
      end
   end

   assign run_out     = (st_q == ST_START) || (st_q == ST_RUN) || (st_q == ST_DELAY);
   assign latched_off = (st_q == ST_LATCH);

endmodule

// File: rtl/ovp_resp_chk.sv
module ovp_resp_chk #(
   parameter int CFG_W  = 8,
   parameter int MODE_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr_en,
   input logic [CFG_W-1:0] cfg_wr_data,
   input logic [CFG_W-1:0] cfg_rd_data,
   input logic             enable_in,
   input logic             fault_in,
   input logic             run_out,
   input logic             latched_off,
   input logic             inv_data_flag,
   input logic             host_alert
);

   localparam logic [MODE_W-1:0] M_BAD = {MODE_W{1'b1}};
   localparam logic [MODE_W-1:0] M_IGN = '0;
   localparam logic [MODE_W-1:0] M_IMM = MODE_W'(2);

   logic wr_bad, wr_good;
   assign wr_bad  = cfg_wr_en && (cfg_wr_data[CFG_W-1 -: MODE_W] == M_BAD);
   assign wr_good = cfg_wr_en && !wr_bad;

   // R2
   reject_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_bad |=> ($stable(cfg_rd_data) && inv_data_flag && host_alert));

   // R3
   valid_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_good |=> (cfg_rd_data == $past(cfg_wr_data)));

   // R4
   no_start_in_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_out && fault_in) |=> !run_out);

   // R5
   ignore_keeps_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_out && enable_in && (cfg_rd_data[CFG_W-1 -: MODE_W] == M_IGN)) |=> run_out);

   // R6
   immediate_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_out && fault_in && (cfg_rd_data[CFG_W-1 -: MODE_W] == M_IMM)) |=> !run_out);

   // R10
   latch_means_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latched_off |-> !run_out);

   // R13
   disable_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_in |=> (!run_out && !latched_off));

endmodule

bind ovp_resp_ctrl ovp_resp_chk #(
   .CFG_W (CFG_W),
   .MODE_W(MODE_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_wr_en    (cfg_wr_en),
   .cfg_wr_data  (cfg_wr_data),
   .cfg_rd_data  (cfg_rd_data),
   .enable_in    (enable_in),
   .fault_in     (fault_in),
   .run_out      (run_out),
   .latched_off  (latched_off),
   .inv_data_flag(inv_data_flag),
   .host_alert   (host_alert)
);

// File: tb/ovp_resp_ctrl_test.sv
module ovp_resp_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr_en = 1'b0;
   logic [7:0] cfg_wr_data = 8'h00;
   logic [7:0] cfg_rd_data;
   logic       enable_in = 1'b0;
   logic       fault_in = 1'b0;
   logic       sw_tick = 1'b0;
   logic       rise_tick = 1'b0;
   logic       run_out, latched_off, inv_data_flag, host_alert;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ovp_resp_ctrl uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_wr_en    (cfg_wr_en),
      .cfg_wr_data  (cfg_wr_data),
      .cfg_rd_data  (cfg_rd_data),
      .enable_in    (enable_in),
      .fault_in     (fault_in),
      .sw_tick      (sw_tick),
      .rise_tick    (rise_tick),
      .run_out      (run_out),
      .latched_off  (latched_off),
      .inv_data_flag(inv_data_flag),
      .host_alert   (host_alert)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_sw();
      sw_tick = 1'b1; step(); sw_tick = 1'b0;
   endtask

   task automatic pulse_rise();
      rise_tick = 1'b1; step(); rise_tick = 1'b0;
   endtask

   task automatic write_cfg(input logic [7:0] v);
      cfg_wr_en = 1'b1; cfg_wr_data = v; step(); cfg_wr_en = 1'b0;
   endtask

   task automatic go_off();
      enable_in = 1'b0; fault_in = 1'b0; step();
   endtask

   task automatic start_up();
      enable_in = 1'b0; fault_in = 1'b0; step();
      enable_in = 1'b1; step();
      pulse_rise();
   endtask

   function automatic int dly_of(input int c);
      if (c <= 1) return 1;
      else if (c <= 4) return 3;
      else return 7;
   endfunction

   function automatic int hic_of(input int c);
      return (c <= 1) ? 1 : c;
   endfunction

   initial begin
      #400000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 cfg", int'(cfg_rd_data), 8'h8A);
      chk("R1 run", int'(run_out), 0);
      chk("R1 latch", int'(latched_off), 0);
      chk("R1 flag", int'(inv_data_flag), 0);
      chk("R1 alert", int'(host_alert), 0);

      // R2 rejected write
      write_cfg(8'hC5);
      chk("R2 cfg kept", int'(cfg_rd_data), 8'h8A);
      chk("R2 flag", int'(inv_data_flag), 1);
      chk("R2 alert", int'(host_alert), 1);
      step();
      chk("R2 alert pulse", int'(host_alert), 0);
      chk("R2 flag sticky", int'(inv_data_flag), 1);
      write_cfg(8'h00);
      chk("R2 flag cleared", int'(inv_data_flag), 0);
      chk("R3 cfg", int'(cfg_rd_data), 8'h00);

      // R4 start blocked by fault in each valid mode
      for (int m = 0; m < 3; m++) begin
         write_cfg(8'(m << 6));
         fault_in = 1'b1; enable_in = 1'b1;
         repeat (5) step();
         chk("R4 blocked", int'(run_out), 0);
         fault_in = 1'b0; step();
         chk("R4 start", int'(run_out), 1);
         go_off();
      end

      // R5 ignore mode, then R3 live change to immediate (R6)
      write_cfg(8'h00);
      start_up();
      fault_in = 1'b1;
      for (int i = 0; i < 10; i++) begin pulse_sw(); pulse_rise(); end
      chk("R5 running", int'(run_out), 1);
      write_cfg(8'h80);
      chk("R3 live cfg", int'(cfg_rd_data), 8'h80);
      chk("R3 old mode this cycle", int'(run_out), 1);
      step();
      chk("R6 stop", int'(run_out), 0);
      chk("R10 latch retry0", int'(latched_off), 1);
      go_off();
      chk("R13 latch cleared", int'(latched_off), 0);
      chk("R13 run off", int'(run_out), 0);

      // R6 immediate from steady run
      start_up();
      fault_in = 1'b1; step();
      chk("R6 immediate", int'(run_out), 0);
      go_off();

      // R7 delay sweep
      for (int c = 0; c < 8; c++) begin
         write_cfg({2'b01, 3'd0, 3'(c)});
         start_up();
         fault_in = 1'b1; step();
         repeat (dly_of(c) - 1) pulse_sw();
         chk($sformatf("R7 code%0d before", c), int'(run_out), 1);
         pulse_sw();
         chk($sformatf("R7 code%0d at", c), int'(run_out), 0);
         chk("R10 latch", int'(latched_off), 1);
         go_off();
      end

      // R8 fault clears mid-delay
      write_cfg({2'b01, 3'd0, 3'd5});
      start_up();
      fault_in = 1'b1; step();
      repeat (6) pulse_sw();
      fault_in = 1'b0; step();
      fault_in = 1'b1; step();
      repeat (6) pulse_sw();
      chk("R8 no early stop", int'(run_out), 1);
      pulse_sw();
      chk("R8 stop after fresh count", int'(run_out), 0);
      go_off();

      // R9 hiccup sweep with unlimited retries
      for (int c = 0; c < 8; c++) begin
         write_cfg({2'b10, 3'd7, 3'(c)});
         start_up();
         fault_in = 1'b1; step();
         chk("R9 shut", int'(run_out), 0);
         fault_in = 1'b0;
         repeat (hic_of(c) - 1) pulse_rise();
         chk($sformatf("R9 code%0d waiting", c), int'(run_out), 0);
         pulse_rise();
         chk($sformatf("R9 code%0d restart", c), int'(run_out), 1);
         go_off();
      end

      // R10 retry allowance sweep, attempts under fault
      for (int n = 1; n < 7; n++) begin
         write_cfg({2'b10, 3'(n), 3'd0});
         start_up();
         fault_in = 1'b1; step();
         repeat (n - 1) pulse_rise();
         chk($sformatf("R10 n%0d not yet", n), int'(latched_off), 0);
         chk("R10 invisible attempt", int'(run_out), 0);
         pulse_rise();
         chk($sformatf("R10 n%0d latched", n), int'(latched_off), 1);
         go_off();
      end

      // R11 unlimited retries
      write_cfg(8'hB8);
      start_up();
      fault_in = 1'b1; step();
      repeat (20) pulse_rise();
      chk("R11 never latch", int'(latched_off), 0);
      go_off();

      // R12 success clears attempt count
      write_cfg(8'h90);
      start_up();
      fault_in = 1'b1; step();
      pulse_rise();
      chk("R12 first fail", int'(latched_off), 0);
      fault_in = 1'b0;
      pulse_rise();
      chk("R12 restart", int'(run_out), 1);
      pulse_rise();
      fault_in = 1'b1; step();
      chk("R12 count cleared", int'(latched_off), 0);
      pulse_rise();
      chk("R12 one attempt", int'(latched_off), 0);
      pulse_rise();
      chk("R12 latch after two", int'(latched_off), 1);
      go_off();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule